// File: doc/BRIEF.md
# Serial Display Memory and Command Port

This block is the host-facing slave of an LED matrix controller. A host drives four slow lines: an active-high chip deselect, a write strobe, a read strobe and one data line. The block runs on a much faster system clock. It synchronises those lines and detects their edges. From the resulting bit stream it decodes a three-bit mode code that selects a read, a write or read-modify-write, or a command stream.

Data transfers address a nibble-wide display memory that holds up to 96 entries. The address advances by itself after every nibble, so one selection can carry a burst of any length. The address wraps at the top of the memory that the current common-line layout uses. Command streams carry 9-bit words. The block decodes them into plain configuration outputs for a scan engine: oscillator enable, display enable, blink, clock role, common layout, output polarity and brightness duty. A second, combinational read port lets the scan engine fetch nibbles.

The serial data output is a pin value plus an output enable. The enable goes high only while the block owns the line. The serial protocol fixes the host-side timing, so there is no valid/ready handshake. All configuration outputs are plain levels.

Top module: `dsi_serial_if`

## Requirements
- R1: After the select line falls, the first three bits captured on write-strobe rising edges are the mode code, first bit most significant. 110 selects read, 101 selects write or read-modify-write, and 100 selects commands. Any other code makes the block ignore all strobes until the select line goes high.
- R2: In write mode, 7 address bits (most significant first) follow the code. Then come 4-bit data nibbles, least significant bit first, each bit captured on a write-strobe rising edge. Each complete nibble is stored in the memory and can then be seen on the scan read port.
- R3: After each nibble the address advances by one. It wraps to 0 after entry 63 when the 8-common layout is selected, and after entry 95 when the 16-common layout is selected.
- R4: In read mode, after the address, each read-strobe falling edge puts the next bit of the addressed nibble on the data output, least significant bit first. After 4 bits the address advances as in R3.
- R5: In mode 101, read-strobe falling edges put out the bits of the current nibble first. The next 4 write-strobe bits then replace that same entry. Only after those 4 bits does the address advance.
- R6: The output enable is high only in the read data phase, and in a read-modify-write output phase (from a read-strobe falling edge until the next write-strobe rising edge). At all other times, including whenever the select line is high, it is low.
- R7: In command mode the block takes consecutive 9-bit words, first bit C8. The final bit C0 is ignored. Further words need no repeated mode code while the select line stays low.
- R8: Command bits C8..C1 are decoded as follows. 00000001 sets the oscillator enable. 00000000 clears both the oscillator enable and the display enable. 00000011 and 00000010 set and clear the display enable. 00001001 and 00001000 set and clear blink.
- R9: 00010xxx sets clock role 2'b10 (follower). 000110xx sets 2'b00 (internal-clock leader). 000111xx sets 2'b01 (external-clock leader). 0010abxx sets the output polarity to a and the 16-common layout to b. 101xdddd sets the duty code to dddd, which means a brightness of (dddd+1)/16. Configuration outputs change only on a complete command word.
- R10: After reset the following values hold: oscillator and display enables low, blink off, clock role 2'b00, 8-common layout, polarity 0, duty code 4'hF, output enable low, and every memory entry 0.
- R11: Raising the select line abandons any transfer. A partly received nibble is not written, and after the select line falls again a new mode code is expected.
- R12: A nibble whose address lies beyond the last entry of the selected layout is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel_hi_i | input | 1 | Host chip deselect, high = idle/abort (asynchronous) |
| wstb_i | input | 1 | Host write strobe, data captured on rising edge (asynchronous) |
| rstb_i | input | 1 | Host read strobe, data driven after falling edge (asynchronous) |
| sdat_i | input | 1 | Host serial data in (asynchronous) |
| sdat_o | output | 1 | Serial data out value |
| sdat_oe | output | 1 | Serial data output enable; low = line released |
| scan_addr_i | input | 7 | Scan engine memory address |
| scan_nib_o | output | 4 | Nibble at scan_addr_i (0 beyond the memory) |
| osc_en_o | output | 1 | Oscillator enable |
| disp_en_o | output | 1 | Display (duty generator) enable |
| blink_o | output | 1 | Blink enable |
| clk_role_o | output | 2 | 00 internal leader, 01 external leader, 10 follower |
| com16_o | output | 1 | 1 = 16-common layout, 0 = 8-common |
| pol_o | output | 1 | Common output polarity select |
| duty_o | output | 4 | Brightness duty code, brightness (code+1)/16 |

## Verification
The hardest case to reach from the ports is read-modify-write. There the output enable must rise on a read strobe and fall on the next write strobe, and the same address must be kept for both halves before it advances. Random bursts of varying length drive this path, and some of them cross the wrap point. Address wrap is reached in each layout by bursts that start at the last entry. A write that lies beyond the 8-common range is checked by switching to the 16-common layout and reading that entry on the scan port. An abort in the middle of a nibble is checked the same way.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  typedef enum logic [2:0] {
    ST_CODE,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_CMD,
    ST_HALT
  } dsi_state_t;

  localparam logic [2:0] CODE_READ  = 3'b110;
  localparam logic [2:0] CODE_WRITE = 3'b101;
  localparam logic [2:0] CODE_CMD   = 3'b100;

  localparam logic [1:0] ROLE_INT_LEAD = 2'b00;
  localparam logic [1:0] ROLE_EXT_LEAD = 2'b01;
  localparam logic [1:0] ROLE_FOLLOW   = 2'b10;
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] stg;
  logic [N-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= {STAGES{IDLE}};
      prev <= IDLE;
    end else begin
      stg  <= {stg[STAGES-2:0], async_i};
      prev <= stg[STAGES-1];
    end
  end

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev;
  assign fall_o = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/dsi_ram.sv
module dsi_ram #(
  parameter int DEPTH = 96,
  parameter int AW    = 7,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && int'(waddr) < DEPTH) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : '0;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : '0;

  p_write_inside_r12: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(waddr) < DEPTH);
endmodule

// File: rtl/dsi_cmd.sv
module dsi_cmd
  import dsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic [7:0] code,
  output logic       osc_en,
  output logic       disp_en,
  output logic       blink,
  output logic [1:0] clk_role,
  output logic       com16,
  output logic       pol,
  output logic [3:0] duty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en   <= 1'b0;
      disp_en  <= 1'b0;
      blink    <= 1'b0;
      clk_role <= ROLE_INT_LEAD;
      com16    <= 1'b0;
      pol      <= 1'b0;
      duty     <= 4'hF;
    end else if (stb) begin
      casez (code)
        8'b0000_0000: begin osc_en <= 1'b0; disp_en <= 1'b0; end
        8'b0000_0001: osc_en <= 1'b1;
        8'b0000_0010: disp_en <= 1'b0;
        8'b0000_0011: disp_en <= 1'b1;
        8'b0000_1000: blink <= 1'b0;
        8'b0000_1001: blink <= 1'b1;
        8'b0001_0???: clk_role <= ROLE_FOLLOW;
        8'b0001_10??: clk_role <= ROLE_INT_LEAD;
        8'b0001_11??: clk_role <= ROLE_EXT_LEAD;
        8'b0010_????: begin pol <= code[3]; com16 <= code[2]; end
        8'b101?_????: duty <= code[3:0];
        default: ;
      endcase
    end
  end

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable({osc_en, disp_en, blink, clk_role, com16, pol, duty}));
  p_sysoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && code == 8'h00) |=> (!osc_en && !disp_en));
endmodule

// File: rtl/dsi_serial_if.sv
module dsi_serial_if
  import dsi_pkg::*;
#(
  parameter int DEPTH_LO    = 64,
  parameter int DEPTH_HI    = 96,
  parameter int AW          = 7,
  parameter int DW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_hi_i,
  input  logic          wstb_i,
  input  logic          rstb_i,
  input  logic          sdat_i,
  output logic          sdat_o,
  output logic          sdat_oe,
  input  logic [AW-1:0] scan_addr_i,
  output logic [DW-1:0] scan_nib_o,
  output logic          osc_en_o,
  output logic          disp_en_o,
  output logic          blink_o,
  output logic [1:0]    clk_role_o,
  output logic          com16_o,
  output logic          pol_o,
  output logic [3:0]    duty_o
);
  localparam int CMD_BITS = 9;
  localparam int BW       = $clog2(CMD_BITS + 1);
  localparam int NW       = $clog2(DW);
  localparam logic [AW-1:0] LAST_LO = AW'(DEPTH_LO - 1);
  localparam logic [AW-1:0] LAST_HI = AW'(DEPTH_HI - 1);

  logic [3:0] lvl, rise, fall;
  dsi_sync #(.N(4), .STAGES(SYNC_STAGES), .IDLE(4'b1111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sdat_i, rstb_i, wstb_i, sel_hi_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic idle, w_up, r_dn, din;
  assign idle = lvl[0];
  assign w_up = rise[1] & ~idle;
  assign r_dn = fall[2] & ~idle;
  assign din  = lvl[3];

  dsi_state_t      state;
  logic [BW-1:0]   bcnt;
  logic [NW-1:0]   rcnt;
  logic [CMD_BITS-2:0] shreg;
  logic [DW-2:0]   wbuf;
  logic [AW-1:0]   addr, addr_next, last;
  logic            is_rd, out_bit, oe;
  logic [DW-1:0]   cur_nib;
  logic            ram_we, cmd_stb;

  assign last      = com16_o ? LAST_HI : LAST_LO;
  assign addr_next = (addr >= last) ? '0 : addr + 1'b1;
  assign ram_we    = (state == ST_WDATA) && w_up && (bcnt == BW'(DW - 1)) && (addr <= last);
  assign cmd_stb   = (state == ST_CMD) && w_up && (bcnt == BW'(CMD_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CODE;
      bcnt    <= '0;
      rcnt    <= '0;
      shreg   <= '0;
      wbuf    <= '0;
      addr    <= '0;
      is_rd   <= 1'b0;
      out_bit <= 1'b0;
      oe      <= 1'b0;
    end else if (idle) begin
      state <= ST_CODE;
      bcnt  <= '0;
      rcnt  <= '0;
      oe    <= 1'b0;
    end else begin
      case (state)
        ST_CODE: if (w_up) begin
          shreg <= {shreg[CMD_BITS-3:0], din};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == BW'(2)) begin
            bcnt <= '0;
            unique case ({shreg[1:0], din})
              CODE_READ:  begin state <= ST_ADDR; is_rd <= 1'b1; end
              CODE_WRITE: begin state <= ST_ADDR; is_rd <= 1'b0; end
              CODE_CMD:   state <= ST_CMD;
              default:    state <= ST_HALT;
            endcase
          end
        end
        ST_ADDR: if (w_up) begin
          addr <= {addr[AW-2:0], din};
          bcnt <= bcnt + 1'b1;
          if (bcnt == BW'(AW - 1)) begin
            bcnt  <= '0;
            state <= is_rd ? ST_RDATA : ST_WDATA;
            oe    <= is_rd;
          end
        end
        ST_RDATA: if (r_dn) begin
          out_bit <= cur_nib[rcnt];
          rcnt    <= rcnt + 1'b1;
          if (rcnt == NW'(DW - 1)) addr <= addr_next;
        end
        ST_WDATA: begin
          if (r_dn) begin
            out_bit <= cur_nib[rcnt];
            rcnt    <= rcnt + 1'b1;
            oe      <= 1'b1;
          end
          if (w_up) begin
            oe         <= 1'b0;
            wbuf[bcnt[NW-1:0]] <= din;
            bcnt       <= bcnt + 1'b1;
            if (bcnt == BW'(DW - 1)) begin
              bcnt <= '0;
              rcnt <= '0;
              addr <= addr_next;
            end
          end
        end
        ST_CMD: if (w_up) begin
          shreg <= {shreg[CMD_BITS-3:0], din};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == BW'(CMD_BITS - 1)) bcnt <= '0;
        end
        default: ;
      endcase
    end
  end

  dsi_ram #(.DEPTH(DEPTH_HI), .AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we), .waddr(addr), .wdata({din, wbuf}),
    .raddr_a(addr), .rdata_a(cur_nib),
    .raddr_b(scan_addr_i), .rdata_b(scan_nib_o)
  );

  dsi_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .stb(cmd_stb), .code(shreg),
    .osc_en(osc_en_o), .disp_en(disp_en_o), .blink(blink_o),
    .clk_role(clk_role_o), .com16(com16_o), .pol(pol_o), .duty(duty_o)
  );

  assign sdat_o  = out_bit;
  assign sdat_oe = oe;

  p_release_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !sdat_oe);
  p_drive_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> (state == ST_RDATA || state == ST_WDATA));
  p_halt_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> (!ram_we && !cmd_stb && !sdat_oe));
  p_bitcount_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt < BW'(CMD_BITS));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> addr <= last);
endmodule

// File: tb/dsi_serial_if_tb.sv
module dsi_serial_if_tb;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_hi = 1'b1, wstb = 1'b1, rstb = 1'b1, sdat = 1'b1;
  logic sdat_o, sdat_oe;
  logic [6:0] scan_addr = '0;
  logic [3:0] scan_nib;
  logic osc_en, disp_en, blink, com16, pol;
  logic [1:0] clk_role;
  logic [3:0] duty;

  int total = 0;
  int bad = 0;
  logic [3:0] model [96];
  bit com16_m = 1'b0;

  always #2.5 clk = ~clk;

  dsi_serial_if u_dut (
    .clk(clk), .rst_n(rst_n), .sel_hi_i(sel_hi), .wstb_i(wstb), .rstb_i(rstb),
    .sdat_i(sdat), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .scan_addr_i(scan_addr),
    .scan_nib_o(scan_nib), .osc_en_o(osc_en), .disp_en_o(disp_en), .blink_o(blink),
    .clk_role_o(clk_role), .com16_o(com16), .pol_o(pol), .duty_o(duty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int last_m();
    return com16_m ? 95 : 63;
  endfunction
  function automatic int nxt(input int a);
    return (a >= last_m()) ? 0 : a + 1;
  endfunction

  task automatic hwait();
    repeat (HP) @(negedge clk);
  endtask
  task automatic sel_on();
    sel_hi = 1'b0; hwait();
  endtask
  task automatic sel_off();
    sel_hi = 1'b1; hwait(); hwait();
  endtask
  task automatic wbit(input logic b);
    sdat = b; wstb = 1'b0; hwait(); wstb = 1'b1; hwait();
  endtask
  task automatic rbit(output logic b, output logic oe);
    rstb = 1'b0; hwait(); b = sdat_o; oe = sdat_oe; rstb = 1'b1; hwait();
  endtask
  task automatic send_code(input logic [2:0] c);
    for (int i = 2; i >= 0; i--) wbit(c[i]);
  endtask
  task automatic send_addr(input logic [6:0] a);
    for (int i = 6; i >= 0; i--) wbit(a[i]);
  endtask
  task automatic send_nib(input logic [3:0] d);
    for (int i = 0; i < 4; i++) wbit(d[i]);
  endtask
  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) wbit(c[i]);
    wbit(1'($urandom()));
  endtask
  task automatic scan_one(input int a, input string req);
    scan_addr = 7'(a); @(negedge clk);
    chk(scan_nib == model[a], req, scan_nib, model[a]);
  endtask
  task automatic scan_all(input string req);
    for (int a = 0; a < 96; a++) scan_one(a, req);
  endtask

  task automatic write_burst(input int a0, input int n);
    int a = a0;
    sel_on(); send_code(3'b101); send_addr(7'(a0));
    for (int k = 0; k < n; k++) begin
      logic [3:0] d = 4'($urandom());
      send_nib(d);
      if (a <= last_m()) model[a] = d;
      a = nxt(a);
    end
    sel_off();
  endtask

  task automatic read_burst(input int a0, input int n);
    int a = a0;
    logic b, oe;
    sel_on(); send_code(3'b110); send_addr(7'(a0));
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 4; j++) begin
        rbit(b, oe);
        chk(b == model[a][j], "R4 read bit", b, model[a][j]);
        chk(oe == 1'b1, "R6 enable in read", oe, 1);
      end
      a = nxt(a);
    end
    sel_off();
    chk(sdat_oe == 1'b0, "R6 released after select high", sdat_oe, 0);
  endtask

  task automatic rmw_burst(input int a0, input int n);
    int a = a0;
    logic b, oe;
    sel_on(); send_code(3'b101); send_addr(7'(a0));
    chk(sdat_oe == 1'b0, "R6 released before rmw read", sdat_oe, 0);
    for (int k = 0; k < n; k++) begin
      logic [3:0] d = 4'($urandom());
      for (int j = 0; j < 4; j++) begin
        rbit(b, oe);
        chk(b == model[a][j], "R5 rmw read bit", b, model[a][j]);
        chk(oe == 1'b1, "R6 enable in rmw read", oe, 1);
      end
      send_nib(d);
      chk(sdat_oe == 1'b0, "R6 released after rmw write", sdat_oe, 0);
      model[a] = d;
      a = nxt(a);
    end
    sel_off();
  endtask

  task automatic cmd_seq(input logic [7:0] c);
    send_cmd(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < 96; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset values
    chk(osc_en == 0, "R10 osc", osc_en, 0);
    chk(disp_en == 0, "R10 disp", disp_en, 0);
    chk(blink == 0, "R10 blink", blink, 0);
    chk(clk_role == 2'b00, "R10 role", clk_role, 0);
    chk(com16 == 0 && pol == 0, "R10 layout", {com16, pol}, 0);
    chk(duty == 4'hF, "R10 duty", duty, 15);
    chk(sdat_oe == 0, "R10 enable", sdat_oe, 0);
    scan_one(0, "R10 memory");

    // R7 R8 R9 commands, code sent once
    sel_on(); send_code(3'b100);
    cmd_seq(8'b0000_0001); chk(osc_en == 1, "R8 osc on", osc_en, 1);
    cmd_seq(8'b0000_0011); chk(disp_en == 1, "R8 disp on", disp_en, 1);
    cmd_seq(8'b0000_1001); chk(blink == 1, "R8 blink on", blink, 1);
    cmd_seq(8'b0000_1000); chk(blink == 0, "R8 blink off", blink, 0);
    cmd_seq(8'b0001_1110); chk(clk_role == 2'b01, "R9 ext leader", clk_role, 1);
    cmd_seq(8'b0001_0101); chk(clk_role == 2'b10, "R9 follower", clk_role, 2);
    cmd_seq(8'b0001_1001); chk(clk_role == 2'b00, "R9 int leader", clk_role, 0);
    cmd_seq(8'b1011_0101); chk(duty == 4'h5, "R9 duty", duty, 5);
    cmd_seq(8'b0010_1100); chk(pol == 1 && com16 == 1, "R9 layout 11", {pol, com16}, 3);
    cmd_seq(8'b0000_0000);
    chk(osc_en == 0 && disp_en == 0, "R8 system off", {osc_en, disp_en}, 0);
    cmd_seq(8'b0000_0001); cmd_seq(8'b0000_0011);
    cmd_seq(8'b0000_0010); chk(disp_en == 0 && osc_en == 1, "R8 disp off", {osc_en, disp_en}, 2);
    cmd_seq(8'b0010_0100); chk(pol == 0 && com16 == 1, "R7 successive word", {pol, com16}, 1);
    sel_off();
    com16_m = 1'b1;

    // R2 R3 random writes in 16-common layout
    for (int t = 0; t < 14; t++) write_burst($urandom_range(0, 95), $urandom_range(1, 6));
    scan_all("R2 write contents");
    write_burst(95, 3);
    scan_one(95, "R3 wrap at 95"); scan_one(0, "R3 wrap to 0"); scan_one(1, "R3 after wrap");

    // R4 reads, R5 read-modify-write
    for (int t = 0; t < 10; t++) read_burst($urandom_range(0, 95), $urandom_range(1, 4));
    read_burst(94, 3);
    for (int t = 0; t < 8; t++) rmw_burst($urandom_range(0, 95), $urandom_range(1, 3));
    rmw_burst(95, 2);
    scan_all("R5 rmw contents");

    // 8-common layout: wrap at 63, out-of-range write ignored
    sel_on(); send_code(3'b100); send_cmd(8'b0010_0000); sel_off();
    com16_m = 1'b0;
    chk(com16 == 0, "R9 layout 8", com16, 0);
    write_burst(63, 2);
    scan_one(63, "R3 wrap at 63"); scan_one(0, "R3 wrap to 0 in 8-common");
    sel_on(); send_code(3'b101); send_addr(7'd70); send_nib(4'hA); sel_off();
    sel_on(); send_code(3'b100); send_cmd(8'b0010_0100); sel_off();
    com16_m = 1'b1;
    scan_one(70, "R12 out-of-range write ignored");

    // R11 abort mid-nibble, then a fresh code works
    sel_on(); send_code(3'b101); send_addr(7'd10); wbit(~model[10][0]); wbit(~model[10][1]); sel_off();
    scan_one(10, "R11 partial nibble discarded");
    sel_on(); send_code(3'b1); sel_off();
    write_burst(11, 1);
    scan_one(11, "R11 new code after abort");

    // R1 unknown codes ignore everything
    begin
      logic b, oe;
      sel_on(); send_code(3'b111); send_addr(7'd12); send_nib(~model[12]);
      rbit(b, oe);
      chk(oe == 0, "R1 unknown code no drive", oe, 0);
      sel_off();
      scan_one(12, "R1 unknown code no write");
      sel_on(); send_code(3'b010); send_addr(7'd13); send_nib(~model[13]); sel_off();
      scan_one(13, "R1 code 010 no write");
      chk(duty == 4'h5, "R1 config untouched", duty, 5);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule